// File: doc/BRIEF.md
# Phase-Presettable NCO Clock Generator

This block generates a square-wave clock from a phase accumulator. A programmable prescaler sets how many system clocks pass between accumulator updates. On each update a 32-bit increment is added to a 32-bit phase value. The most significant bit of that phase value drives the output, so the duty cycle stays at one half and only the frequency is programmed. The output frequency is `f_sys * inc / (2^32 * prescale)`.

A single 32-bit configuration write does two things. Its low half sets the prescale period, and its high half is loaded into the upper half of the phase value. The output therefore starts part-way through its cycle. Two instances written in the same cycle stay aligned, and their phase relation is fixed. For example, one instance can drive a serial bit clock and another a word-select clock that leads the data by one bit period.

Top module: `nco_clock_gen`

## Requirements
- R1: While enabled, the increment is added to the phase value once every P system clocks. P is the prescale field, bits [15:0] of the configuration word. The first addition occurs on the P-th rising edge after the configuration write.
- R2: While enabled, `clkOut` equals bit 31 of the phase value. With increment 2^31 the output toggles on every update. With increment 2^26 it toggles every 32 updates.
- R3: A configuration write copies bits [31:16] of the word into bits [31:16] of the phase value. Bits [15:0] of the phase value keep their previous contents.
- R4: A prescale field of 0 behaves exactly as a prescale field of 1.
- R5: A configuration write restarts the prescale count from zero. No addition occurs in the cycle of the write, even if that cycle would have ended a prescale period.
- R6: While `enable` is low, the phase value and the prescale count hold, and `clkOut` is low. When `enable` returns high, counting resumes from the held state.
- R7: After reset, the phase value and the increment are zero, the prescale period is one, and `clkOut` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run enable; output held low when low |
| cfgWrite | input | 1 | Strobe: load configuration word |
| cfgData | input | 32 | [31:16] phase preset, [15:0] prescale period |
| incWrite | input | 1 | Strobe: load increment |
| incData | input | 32 | Phase increment per update |
| clkOut | output | 1 | Generated clock |

## Verification
A configuration write and the end of a prescale period can fall on the same clock edge. In that case the write must win: no addition happens, and the count restarts. The bench provokes this by starting the generator with prescale 2. It then issues a second configuration write exactly on the edge where the first addition is due. It judges the result by the output. The output must stay low on that edge and on the next one, and must go high only two edges after the second write. Other vectors and directed tests cover the one-bit phase lead and the retention of the lower half of the phase value.

// File: rtl/nco_pkg.sv
package nco_pkg;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic loadPhase;  // configuration write: preset upper phase half
    logic step;       // add increment to phase
  } ncoStrobe_t;

  // Zero prescale is treated as one
  function automatic logic [15:0] fixPeriod(input logic [15:0] raw);
    return (raw == '0) ? 16'd1 : raw;
  endfunction

endpackage

// File: rtl/nco_ctrl.sv
module nco_ctrl
  import nco_pkg::*;
#(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             cfgWrite,
  input  logic [PRE_W-1:0] cfgPrescale,
  output ncoStrobe_t       strobe
);

  logic [PRE_W-1:0] period;
  logic [PRE_W-1:0] count;
  logic             lastTick;

  assign lastTick = (count == period - 1'b1);

  always_comb begin
    strobe.loadPhase = cfgWrite;
    strobe.step      = enable && !cfgWrite && lastTick;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      period <= PRE_W'(1);
      count  <= '0;
    end else if (cfgWrite) begin
      period <= (cfgPrescale == '0) ? PRE_W'(1) : cfgPrescale;
      count  <= '0;
    end else if (enable) begin
      count <= lastTick ? '0 : count + 1'b1;
    end
  end

  // count stays inside the period
  p_count_in_period_r1 : assert property (@(posedge clk) disable iff (!rstN)
    count < period);

  // write restarts the prescaler
  p_restart_r5 : assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |=> count == '0);

  // zero prescale becomes one
  p_zero_as_one_r4 : assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && cfgPrescale == '0) |=> period == PRE_W'(1));

  // count holds while disabled
  p_count_hold_r6 : assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !cfgWrite) |=> $stable(count));

endmodule

// File: rtl/nco_datapath.sv
module nco_datapath
  import nco_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int PH_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ncoStrobe_t       strobe,
  input  logic [PH_W-1:0]  phasePreset,
  input  logic             incWrite,
  input  logic [ACC_W-1:0] incData,
  output logic             accMsb
);

  localparam int LOW_W = ACC_W - PH_W;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] inc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0;
      inc <= '0;
    end else begin
      if (incWrite) inc <= incData;
      if (strobe.loadPhase)
        acc[ACC_W-1:LOW_W] <= phasePreset;
      else if (strobe.step)
        acc <= acc + inc;
    end
  end

  assign accMsb = acc[ACC_W-1];

  // preset touches only the upper half
  p_preset_r3 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadPhase |=> (acc[ACC_W-1:LOW_W] == $past(phasePreset)) &&
                         (acc[LOW_W-1:0] == $past(acc[LOW_W-1:0])));

  // phase holds without a step or load
  p_acc_hold_r6 : assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.step && !strobe.loadPhase) |=> $stable(acc));

  // load and step are never both asserted
  p_load_excl_r5 : assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.step && strobe.loadPhase));

endmodule

// File: rtl/nco_clock_gen.sv
module nco_clock_gen
  import nco_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             cfgWrite,
  input  logic [ACC_W-1:0] cfgData,
  input  logic             incWrite,
  input  logic [ACC_W-1:0] incData,
  output logic             clkOut
);

  localparam int PH_W = ACC_W - PRE_W;

  ncoStrobe_t strobe;
  logic       accMsb;

  nco_ctrl #(.PRE_W(PRE_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .cfgWrite   (cfgWrite),
    .cfgPrescale(cfgData[PRE_W-1:0]),
    .strobe     (strobe)
  );

  nco_datapath #(.ACC_W(ACC_W), .PH_W(PH_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .phasePreset(cfgData[ACC_W-1:PRE_W]),
    .incWrite   (incWrite),
    .incData    (incData),
    .accMsb     (accMsb)
  );

  assign clkOut = enable & accMsb;

  // output low while disabled
  p_out_low_r6 : assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !clkOut);

endmodule

// File: tb/nco_clock_gen_bench.sv
`timescale 1ns/1ps
module nco_clock_gen_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        cfgWrite = 1'b0;
  logic [31:0] cfgData = '0;
  logic        incWrite = 1'b0;
  logic [31:0] incData = '0;
  logic        clkOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  nco_clock_gen u_nco_clock_gen (
    .clk(clk), .rstN(rstN), .enable(enable),
    .cfgWrite(cfgWrite), .cfgData(cfgData),
    .incWrite(incWrite), .incData(incData),
    .clkOut(clkOut)
  );

  typedef struct packed {
    logic [15:0] pre;
    logic [15:0] ph;
    logic [31:0] inc;
    logic [15:0] edges;
    logic        expOut;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{16'd1,   16'h0000, 32'h8000_0000, 16'd1,   1'b1}, // R1 R2
    '{16'd1,   16'h0000, 32'h8000_0000, 16'd2,   1'b0}, // R2 toggle
    '{16'd4,   16'h0000, 32'h8000_0000, 16'd3,   1'b0}, // R1 before period
    '{16'd4,   16'h0000, 32'h8000_0000, 16'd4,   1'b1}, // R1 at period
    '{16'd4,   16'h0000, 32'h8000_0000, 16'd8,   1'b0}, // R1 second update
    '{16'd0,   16'h0000, 32'h8000_0000, 16'd1,   1'b1}, // R4 zero as one
    '{16'd2,   16'h0000, 32'h0400_0000, 16'd62,  1'b0}, // R2 slow
    '{16'd2,   16'h0000, 32'h0400_0000, 16'd64,  1'b1}, // R2 slow
    '{16'd1,   16'h8000, 32'h0000_0000, 16'd5,   1'b1}, // R3 preset
    '{16'd1,   16'h0400, 32'h0400_0000, 16'd30,  1'b0}, // R3 lead
    '{16'd1,   16'h0400, 32'h0400_0000, 16'd31,  1'b1}, // R3 lead
    '{16'd100, 16'h0000, 32'h8000_0000, 16'd99,  1'b0}, // R1 long
    '{16'd100, 16'h0000, 32'h8000_0000, 16'd100, 1'b1}, // R1 long
    '{16'd3,   16'h7000, 32'h0800_0000, 16'd5,   1'b0}, // R1 R3
    '{16'd3,   16'h7000, 32'h0800_0000, 16'd6,   1'b1}  // R1 R3
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: clkOut=%b expected %b", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; enable = 1'b0; cfgWrite = 1'b0; incWrite = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // write both registers at a negedge; returns after the write edge
  task automatic writeBoth(input logic [15:0] pre, input logic [15:0] ph,
                           input logic [31:0] inc, input logic en);
    cfgWrite = 1'b1; cfgData = {ph, pre};
    incWrite = 1'b1; incData = inc;
    enable   = en;
    @(negedge clk);
    cfgWrite = 1'b0; incWrite = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R7 reset state
    doReset();
    #1 check("R7 reset", clkOut, 1'b0);

    for (int i = 0; i < NV; i++) begin
      doReset();
      writeBoth(VECS[i].pre, VECS[i].ph, VECS[i].inc, 1'b1);
      repeat (int'(VECS[i].edges)) @(negedge clk);
      #1 check($sformatf("R1/R2 vector %0d", i), clkOut, VECS[i].expOut);
    end

    // R6 disable holds state, output low
    doReset();
    writeBoth(16'd1, 16'h0000, 32'h8000_0000, 1'b1);
    @(negedge clk);
    #1 check("R6 running high", clkOut, 1'b1);
    enable = 1'b0;
    #1 check("R6 low when disabled", clkOut, 1'b0);
    repeat (3) @(negedge clk);
    #1 check("R6 still low", clkOut, 1'b0);
    enable = 1'b1;
    #1 check("R6 phase held", clkOut, 1'b1);
    @(negedge clk);
    #1 check("R6 resumes", clkOut, 1'b0);

    // R5 write on a period boundary wins over the step
    doReset();
    writeBoth(16'd2, 16'h0000, 32'h8000_0000, 1'b1);
    @(negedge clk);
    cfgWrite = 1'b1; cfgData = {16'h0000, 16'd2};
    @(negedge clk);
    cfgWrite = 1'b0;
    #1 check("R5 no step on write edge", clkOut, 1'b0);
    @(negedge clk);
    #1 check("R5 count restarted", clkOut, 1'b0);
    @(negedge clk);
    #1 check("R5 step after restart", clkOut, 1'b1);

    // R3 lower phase half retained across a write
    doReset();
    writeBoth(16'd1, 16'h7FFF, 32'h0000_8000, 1'b1);
    @(negedge clk);
    #1 check("R3 below carry", clkOut, 1'b0);
    enable = 1'b0;
    cfgWrite = 1'b1; cfgData = {16'h7FFF, 16'd1};
    @(negedge clk);
    cfgWrite = 1'b0; enable = 1'b1;
    @(negedge clk);
    #1 check("R3 lower half kept", clkOut, 1'b1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule